// File: doc/BRIEF.md
# Link Power Status Interface Controller

This block sits between a physical layer and a link layer. It samples the power status line that the link layer drives and sets the power state of the parallel interface between the two. A low pulse shorter than a set threshold is ignored, so a link layer may drive the line either steady high or as a pulse train. A low that lasts longer than the first threshold puts the interface into a reset state. In that state the control and data lines and the request line are held at zero, but the forwarded system clock keeps running. A low that lasts longer than a second, larger threshold moves the interface into a disabled state, where the clock enable is also dropped.

When a high sample is seen in either low-power state, the interface returns to normal. An initialisation strobe lasting one cycle marks that return, so that interface start-up logic elsewhere can begin its sequence. A separate output reports whether the link layer counts as active. That output combines the qualified power status with a link-control bit from software. The link-control bit never affects the interface state.

Top module: `lpsi_ctrl`

## Requirements
- R1: Each clock edge that samples `lps_i` low adds one to a run count. Each edge that samples it high clears the count. On the edge after the run reaches RST_THRESH+1 (129) consecutive low samples, `state_o` leaves normal (00). A run of 128 lows followed by a high sample leaves the state at normal.
- R2: In the reset state (`state_o` = 01), `ctl_o`, `data_o` and `req_o` are all zero and `clk_en_o` is 1.
- R3: On the edge after the run reaches DIS_THRESH+1 (1281) consecutive low samples, `state_o` becomes disabled (10). In that state `clk_en_o` is 0 and `ctl_o`, `data_o` and `req_o` are zero. The state never goes straight from normal to disabled.
- R4: While `rst_ni` is low, `state_o` is disabled (10) and `clk_en_o` is 0. After reset the state stays disabled until a high sample of `lps_i` is seen.
- R5: In the reset or disabled state, the edge after a high sample returns `state_o` to normal. On that same edge `init_o` goes high for exactly one cycle. `init_o` is 0 at all other times.
- R6: `link_active_o` is 1 exactly when `state_o` is normal and `lctrl_i` is 1.
- R7: `lctrl_i` has no effect on `state_o`, `clk_en_o` or the gating of the other outputs.
- R8: `state_o` never takes the code 11.
- R9: In the normal state, `ctl_o`, `data_o` and `req_o` follow `ctl_i`, `data_i` and `req_i` in the same cycle, and `clk_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| lps_i | input | 1 | Link power status line, steady or pulsed |
| lctrl_i | input | 1 | Software link-control bit |
| ctl_i | input | CTL_W | Control lines from the interface core |
| data_i | input | DATA_W | Data lines from the interface core |
| req_i | input | 1 | Request line from the link layer |
| ctl_o | output | CTL_W | Gated control lines toward the link layer |
| data_o | output | DATA_W | Gated data lines toward the link layer |
| req_o | output | 1 | Gated request toward the interface core |
| clk_en_o | output | 1 | Enable for the forwarded system clock |
| state_o | output | 2 | Interface state: 00 normal, 01 reset, 10 disabled |
| init_o | output | 1 | One-cycle strobe on return to normal |
| link_active_o | output | 1 | Link layer counts as active |

## Verification
The assertions check several rules on every cycle. A sampled high always clears inactivity on the next edge. The deep threshold implies the shallow one. The code 11 never appears, and the initialisation strobe lasts a single cycle. Normal never jumps straight to disabled, and disabled never falls back to reset. Gated outputs stay quiet and the clock enable stays low in the low-power states. The exact threshold boundaries (128 against 129 lows, and 1280 against 1281) and pulse trains with short lows can only be shown by the bench's scenarios. So can the cycle in which the state changes and the fact that the link-control bit leaves the state alone. The bench compares all of these against a cycle model driven by random and directed segments.

// File: rtl/lpsi_pkg.sv
package lpsi_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'b00,
    ST_RST  = 2'b01,
    ST_DIS  = 2'b10
  } lpsi_state_e;
endpackage

// File: rtl/lpsi_low_timer.sv
module lpsi_low_timer #(
  parameter int RST_THRESH = 128,
  parameter int DIS_THRESH = 1280
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lps_i,
  output logic inactive_o,
  output logic deep_o
);
  localparam int SAT   = DIS_THRESH + 1;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_THRESH);
  localparam logic [CNT_W-1:0] DIS_V = CNT_W'(DIS_THRESH);

  logic [CNT_W-1:0] run_q;

  // reset to saturation: hardware reset looks like a long low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= SAT_V;
    else if (lps_i)          run_q <= '0;
    else if (run_q != SAT_V) run_q <= run_q + 1'b1;
  end

  assign inactive_o = run_q > RST_V;
  assign deep_o     = run_q > DIS_V;

  assert_high_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lps_i |=> !inactive_o);
  assert_deep_implies_inactive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_o |-> inactive_o);
endmodule

// File: rtl/lpsi_fsm.sv
module lpsi_fsm
  import lpsi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        inactive_i,
  input  logic        deep_i,
  output lpsi_state_e state_o,
  output logic        init_o
);
  lpsi_state_e state_q, state_d;
  logic        init_q;

  always_comb begin
    if (deep_i)          state_d = ST_DIS;
    else if (inactive_i) state_d = (state_q == ST_DIS) ? ST_DIS : ST_RST;
    else                 state_d = ST_NORM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DIS;
      init_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      init_q  <= (state_q != ST_NORM) && (state_d == ST_NORM);
    end
  end

  assign state_o = state_q;
  assign init_o  = init_q;

  assert_legal_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11);
  assert_init_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> !init_q);
  assert_init_on_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> (state_q == ST_NORM));
  assert_no_norm_to_dis_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORM) |=> (state_q != ST_DIS));
  assert_no_dis_to_rst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIS) |=> (state_q != ST_RST));
endmodule

// File: rtl/lpsi_gate.sv
module lpsi_gate
  import lpsi_pkg::*;
#(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input  lpsi_state_e       state_i,
  input  logic              lctrl_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              req_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              req_o,
  output logic              clk_en_o,
  output logic              link_active_o
);
  logic live;
  assign live          = state_i == ST_NORM;
  assign ctl_o         = live ? ctl_i  : '0;
  assign data_o        = live ? data_i : '0;
  assign req_o         = live & req_i;
  assign clk_en_o      = state_i != ST_DIS;
  assign link_active_o = live & lctrl_i;
endmodule

// File: rtl/lpsi_ctrl.sv
module lpsi_ctrl
  import lpsi_pkg::*;
#(
  parameter int RST_THRESH = 128,
  parameter int DIS_THRESH = 1280,
  parameter int CTL_W      = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lps_i,
  input  logic              lctrl_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              req_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              req_o,
  output logic              clk_en_o,
  output logic [1:0]        state_o,
  output logic              init_o,
  output logic              link_active_o
);
  logic        inactive, deep;
  lpsi_state_e state;

  lpsi_low_timer #(.RST_THRESH(RST_THRESH), .DIS_THRESH(DIS_THRESH)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .lps_i(lps_i),
    .inactive_o(inactive), .deep_o(deep)
  );

  lpsi_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .inactive_i(inactive), .deep_i(deep),
    .state_o(state), .init_o(init_o)
  );

  lpsi_gate #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_gate (
    .state_i(state), .lctrl_i(lctrl_i), .ctl_i(ctl_i), .data_i(data_i), .req_i(req_i),
    .ctl_o(ctl_o), .data_o(data_o), .req_o(req_o),
    .clk_en_o(clk_en_o), .link_active_o(link_active_o)
  );

  assign state_o = state;

  assert_quiet_outputs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'b00) |-> (ctl_o == '0 && data_o == '0 && !req_o));
  assert_clk_off_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10) |-> !clk_en_o);
  assert_active_needs_norm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_active_o |-> (state_o == 2'b00 && lctrl_i));
endmodule

// File: tb/lpsi_ctrl_test.sv
`timescale 1ns/1ps
module lpsi_ctrl_test;
  localparam int RT = 128, DT = 1280, SAT = DT + 1;

  logic clk = 0, rst_n = 0, lps = 0, lctrl = 0, req = 0;
  logic [1:0] ctl = 0;
  logic [7:0] data = 0;
  logic [1:0] ctl_o, state_o;
  logic [7:0] data_o;
  logic req_o, clk_en_o, init_o, link_active_o;
  int total = 0, bad = 0;
  int m_cnt, m_st;
  bit m_init;
  bit saw_leave;

  always #2.5 clk = ~clk;

  lpsi_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .lps_i(lps), .lctrl_i(lctrl),
    .ctl_i(ctl), .data_i(data), .req_i(req),
    .ctl_o(ctl_o), .data_o(data_o), .req_o(req_o), .clk_en_o(clk_en_o),
    .state_o(state_o), .init_o(init_o), .link_active_o(link_active_o)
  );

  // cycle model from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= SAT; m_st <= 2; m_init <= 0;
    end else begin : upd
      int nst;
      if (m_cnt > DT)      nst = 2;
      else if (m_cnt > RT) nst = (m_st == 2) ? 2 : 1;
      else                 nst = 0;
      m_init <= (m_st != 0) && (nst == 0);
      m_st   <= nst;
      m_cnt  <= lps ? 0 : ((m_cnt == SAT) ? SAT : m_cnt + 1);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_gate(int st, int v);
    return (st == 0) ? v : 0;
  endfunction

  task automatic compare();
    chk(state_o == m_st[1:0], "R1 state", state_o, m_st);
    chk(state_o != 2'b11, "R8 code", state_o, 0);
    chk(clk_en_o == (m_st != 2), "R3 clk_en", clk_en_o, m_st != 2);
    chk(ctl_o == exp_gate(m_st, ctl), m_st == 0 ? "R9 ctl" : "R2 ctl", ctl_o, exp_gate(m_st, ctl));
    chk(data_o == exp_gate(m_st, data), m_st == 0 ? "R9 data" : "R2 data", data_o, exp_gate(m_st, data));
    chk(req_o == exp_gate(m_st, req), m_st == 0 ? "R9 req" : "R2 req", req_o, exp_gate(m_st, req));
    chk(init_o == m_init, "R5 init", init_o, m_init);
    chk(link_active_o == (m_st == 0 && lctrl), "R6 link_active", link_active_o, m_st == 0 && lctrl);
    if (state_o != 0) saw_leave = 1;
  endtask

  // R7: lctrl toggled at random throughout; state is compared to a model blind to it
  task automatic seg(bit lv, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      lps = lv;
      lctrl = $urandom_range(0, 7) != 0 ? lctrl : ~lctrl;
      ctl = 2'($urandom); data = 8'($urandom); req = 1'($urandom);
    end
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(state_o == 2'b10, "R4 reset state", state_o, 2);
    chk(clk_en_o == 0, "R4 reset clk_en", clk_en_o, 0);
    rst_n = 1;
    seg(0, 40);
    chk(state_o == 2'b10, "R4 stays disabled", state_o, 2);
    seg(1, 4);
    // 128 lows must not leave normal
    saw_leave = 0;
    seg(0, RT); seg(1, 4);
    chk(saw_leave == 0, "R1 128 lows", saw_leave, 0);
    // 129 lows: brief reset, then back
    saw_leave = 0;
    seg(0, RT + 1); seg(1, 4);
    chk(saw_leave == 1, "R1 129 lows", saw_leave, 1);
    seg(0, DT); seg(1, 4);
    seg(0, DT + 1); seg(1, 4);
    // pulse train with short lows stays normal
    saw_leave = 0;
    for (int k = 0; k < 20; k++) begin seg(0, RT - 1); seg(1, 1); end
    seg(1, 2);
    chk(saw_leave == 0, "R1 pulse train", saw_leave, 0);
    // R7 directed: lctrl low while active, state stays normal
    lctrl = 0; seg(1, 3);
    chk(state_o == 2'b00, "R7 lctrl low", state_o, 0);
    for (int k = 0; k < 30; k++) begin
      seg(0, $urandom_range(1, 1500));
      seg(1, $urandom_range(1, 40));
    end
    // mid-run hardware reset
    seg(1, 5);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(state_o == 2'b10, "R4 async reset", state_o, 2);
    rst_n = 1; lps = 1;
    seg(1, 5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule